// File: doc/BRIEF.md
# Phase-Correct PWM Sample Player

This block turns a stream of 8-bit unsigned audio samples into a centre-aligned pulse-width waveform. An external low-pass network then recovers the analog signal from it. An internal count walks up from 0 to its top value and back down again, one step per clock with no prescaler. The output is high while the count sits below the active compare value. Because the up ramp and the down ramp are mirror images, the output edges sit symmetrically about the bottom of each period, and one period lasts 510 clocks.

Samples arrive over a valid/ready handshake into a one-entry holding buffer. The active compare value is refreshed from that buffer only when the count stands at its top, so a sample never changes the waveform partway through a half-period. At the bottom of every period a one-cycle tick asks the sample source for the next value. An inversion select flips the polarity of the output, and dropping the enable forces the output low and returns the count to zero.

Top module: `pwm_sample_player`

## Requirements
- R1: During and after reset the output and the tick are low, the count and the active compare value are zero, and the buffer is empty, so `smp_ready_o` is 1.
- R2: While enabled, the count steps once per clock through 0,1,…,255,254,…,1 and repeats, so the period is 510 clocks and consecutive ticks are exactly 510 cycles apart.
- R3: With `inv_i`=0 the output is 1 exactly in the cycles whose count is below the active compare value. It falls at the compare match on the rising ramp and rises again as the falling ramp passes below the match, giving 2·C−1 high cycles per period for a compare value C of 1 or more.
- R4: A buffered sample becomes the active compare value only on the clock edge at which the count is 255. The state with count 255 still uses the old value, and a sample accepted partway up the ramp leaves the rest of that rising ramp unchanged.
- R5: If the buffer is empty when the count reaches 255, the active compare value is kept and the duty cycle repeats unchanged.
- R6: A compare value of 0 keeps the output low for the whole period. A compare value of 255 keeps it high for 509 of the 510 cycles, low only in the cycle with count 255.
- R7: With `inv_i`=1 the output is the complement of the R3 output while enabled. A compare value of 100 then gives 311 high cycles per period.
- R8: A clock edge with `en_i`=0 forces the output low and the count to 0. After enable returns, the first tick comes 510 clocks after the first enabled edge.
- R9: `smp_ready_o` is 1 exactly when the buffer is empty. A handshake with `smp_valid_i`=1 and `smp_ready_o`=1 fills it, which makes `smp_ready_o` 0 from the next cycle until the buffer is moved to the active compare value at count 255.
- R10: `tick_o` is high for one cycle per period: only while enabled, and only in the cycle whose count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count advances on every rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces output low and count to zero |
| inv_i | input | 1 | Output polarity select, 1 = inverted |
| smp_valid_i | input | 1 | Sample offered on `smp_data_i` |
| smp_data_i | input | 8 | Unsigned sample value |
| smp_ready_o | output | 1 | Holding buffer empty, sample can be taken |
| pwm_o | output | 1 | Pulse-width output |
| tick_o | output | 1 | One-cycle strobe at the bottom of each period |

## Verification
Every output is registered from next-state values. `pwm_o`, `tick_o` and `smp_ready_o` therefore show the effect of a stimulus in the first cycle after the clock edge that samples it, one register deep. The bench changes its inputs on the falling edge, advances its model on the rising edge, and compares all three outputs 1 ns after that rising edge. Compare-value reloads appear one cycle after the count-255 state, and the bench's window counts of high cycles per period start at a tick so that every period seen is complete.

// File: rtl/pwm_player_pkg.sv
`timescale 1ns/1ps
package pwm_player_pkg;

    // Direction of the next count step
    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

endpackage

// File: rtl/pwm_tri_counter.sv
`timescale 1ns/1ps
module pwm_tri_counter
    import pwm_player_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             at_top_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_BOT = '0;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_PRE_TOP = CNT_TOP - CNT_ONE;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        slope_e           slope;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (!en_i) begin
            ctr_d.cnt   = CNT_BOT;
            ctr_d.slope = SLOPE_UP;
        end else if (ctr_q.slope == SLOPE_UP) begin
            ctr_d.cnt = ctr_q.cnt + CNT_ONE;
            if (ctr_q.cnt == CNT_PRE_TOP) begin
                ctr_d.slope = SLOPE_DOWN;
            end
        end else begin
            ctr_d.cnt = ctr_q.cnt - CNT_ONE;
            if (ctr_q.cnt == CNT_ONE) begin
                ctr_d.slope = SLOPE_UP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{cnt: CNT_BOT, slope: SLOPE_UP};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o      = ctr_q.cnt;
    assign cnt_next_o = ctr_d.cnt;
    assign at_top_o   = en_i && (ctr_q.cnt == CNT_TOP);

endmodule

// File: rtl/pwm_sample_shadow.sv
`timescale 1ns/1ps
module pwm_sample_shadow #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_top_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic [DATA_W-1:0] cmp_next_o
);

    typedef struct packed {
        logic [DATA_W-1:0] held;
        logic [DATA_W-1:0] cmp;
        logic              full;
    } buf_t;

    buf_t buf_d, buf_q;
    logic take;

    always_comb begin
        buf_d = buf_q;
        take  = valid_i && !buf_q.full;
        // reload point: only at the apex of the count
        if (at_top_i && buf_q.full) begin
            buf_d.cmp  = buf_q.held;
            buf_d.full = 1'b0;
        end
        if (take) begin
            buf_d.held = data_i;
            buf_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign ready_o    = !buf_q.full;
    assign cmp_o      = buf_q.cmp;
    assign cmp_next_o = buf_d.cmp;

endmodule

// File: rtl/pwm_edge_stage.sv
`timescale 1ns/1ps
module pwm_edge_stage #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             inv_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] cmp_next_i,
    output logic             pwm_o,
    output logic             tick_o
);

    typedef struct packed {
        logic pwm;
        logic tick;
    } edge_t;

    edge_t edge_d, edge_q;
    logic  below;

    always_comb begin
        below       = cnt_next_i < cmp_next_i;
        edge_d.pwm  = en_i && (below ^ inv_i);
        edge_d.tick = en_i && (cnt_next_i == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign pwm_o  = edge_q.pwm;
    assign tick_o = edge_q.tick;

endmodule

// File: rtl/pwm_sample_player.sv
`timescale 1ns/1ps
module pwm_sample_player #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         inv_i,
    input  logic         smp_valid_i,
    input  logic [W-1:0] smp_data_i,
    output logic         smp_ready_o,
    output logic         pwm_o,
    output logic         tick_o
);

    logic [W-1:0] cnt_w;
    logic [W-1:0] cnt_next_w;
    logic [W-1:0] cmp_w;
    logic [W-1:0] cmp_next_w;
    logic         at_top_w;

    pwm_tri_counter #(.CNT_W(W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .cnt_o      (cnt_w),
        .cnt_next_o (cnt_next_w),
        .at_top_o   (at_top_w)
    );

    pwm_sample_shadow #(.DATA_W(W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .at_top_i   (at_top_w),
        .valid_i    (smp_valid_i),
        .data_i     (smp_data_i),
        .ready_o    (smp_ready_o),
        .cmp_o      (cmp_w),
        .cmp_next_o (cmp_next_w)
    );

    pwm_edge_stage #(.CNT_W(W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .inv_i      (inv_i),
        .cnt_next_i (cnt_next_w),
        .cmp_next_i (cmp_next_w),
        .pwm_o      (pwm_o),
        .tick_o     (tick_o)
    );

endmodule

// File: rtl/pwm_player_checker.sv
`timescale 1ns/1ps
module pwm_player_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_i,
    input logic         valid_i,
    input logic         ready_o,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic         pwm_o,
    input logic         tick_o
);

    localparam logic [W-1:0] C_TOP = '1;
    localparam logic [W-1:0] C_ONE = {{(W-1){1'b0}}, 1'b1};

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ((cnt == $past(cnt) + C_ONE) || (cnt == $past(cnt) - C_ONE)));

    assert_reload_at_apex_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp != $past(cmp)) |-> (($past(cnt) == C_TOP) && $past(en_i)));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ((cnt == '0) && !pwm_o && !tick_o));

    assert_buffer_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

    assert_tick_at_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (cnt == '0));

endmodule

bind pwm_sample_player pwm_player_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .valid_i (smp_valid_i),
    .ready_o (smp_ready_o),
    .cnt     (cnt_w),
    .cmp     (cmp_w),
    .pwm_o   (pwm_o),
    .tick_o  (tick_o)
);

// File: tb/test_pwm_sample_player.sv
`timescale 1ns/1ps
module test_pwm_sample_player;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD_CYC = 510;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       inv_i = 1'b0;
    logic       smp_valid_i = 1'b0;
    logic [7:0] smp_data_i = '0;
    logic       smp_ready_o;
    logic       pwm_o;
    logic       tick_o;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    int   m_cnt  = 0;
    logic m_up   = 1'b1;
    int   m_cmp  = 0;
    int   m_held = 0;
    logic m_full = 1'b0;
    logic m_out  = 1'b0;
    logic m_tick = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_sample_player #(.W(8)) i_pwm_sample_player (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .inv_i       (inv_i),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .smp_ready_o (smp_ready_o),
        .pwm_o       (pwm_o),
        .tick_o      (tick_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic high_for(input int cnt, input int cmp, input logic inv);
        return (cnt < cmp) ^ inv;
    endfunction

    task automatic model_edge(input logic en, input logic inv, input logic vld, input logic [7:0] dat);
        logic take;
        take = vld && !m_full;
        if (en && m_cnt == 255 && m_full) begin
            m_cmp  = m_held;
            m_full = 1'b0;
        end
        if (take) begin
            m_held = dat;
            m_full = 1'b1;
        end
        if (!en) begin
            m_cnt = 0;
            m_up  = 1'b1;
        end else if (m_up) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 255) m_up = 1'b0;
        end else begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_up = 1'b1;
        end
        m_out  = en && high_for(m_cnt, m_cmp, inv);
        m_tick = en && (m_cnt == 0);
    endtask

    task automatic step(input logic en, input logic inv, input logic vld, input logic [7:0] dat);
        @(negedge clk);
        en_i = en; inv_i = inv; smp_valid_i = vld; smp_data_i = dat;
        @(posedge clk);
        model_edge(en, inv, vld, dat);
        #1;
        check(inv ? "R7 pwm" : "R3 pwm", pwm_o, m_out);
        check("R10 tick", tick_o, m_tick);
        check("R9 ready", smp_ready_o, !m_full);
    endtask

    task automatic wait_tick(input logic inv);
        for (int i = 0; i < 2 * PERIOD_CYC; i++) begin
            step(1'b1, inv, 1'b0, 8'h00);
            if (tick_o) break;
        end
    endtask

    task automatic run_count(input int n, input logic inv, output int highs, output int ticks);
        highs = 0; ticks = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1, inv, 1'b0, 8'h00);
            highs += int'(pwm_o);
            ticks += int'(tick_o);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int highs, ticks, c0, wait_n;
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 pwm in reset", pwm_o, 0);
        check("R1 tick in reset", tick_o, 0);
        check("R1 ready in reset", smp_ready_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 8'h00);
        check("R1 pwm after reset", pwm_o, 0);

        // R6 / R2: compare value 0 from reset
        wait_tick(1'b0);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        check("R6 highs with compare 0", highs, 0);
        check("R2 ticks per 510 cycles", ticks, 1);
        check("R2 tick at cycle 510", tick_o, 1);

        // R6: compare value 255
        step(1'b1, 1'b0, 1'b1, 8'd255);
        wait_tick(1'b0);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        check("R6 highs with compare 255", highs, 509);

        // R3 / R5: compare value 100, then no new samples
        step(1'b1, 1'b0, 1'b1, 8'd100);
        wait_tick(1'b0);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        check("R3 highs with compare 100", highs, 199);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        check("R5 duty kept without new sample", highs, 199);
        check("R2 tick spacing under hold", ticks, 1);

        // R7: inverted polarity
        wait_tick(1'b1);
        run_count(PERIOD_CYC, 1'b1, highs, ticks);
        check("R7 inverted highs with compare 100", highs, 311);

        // R4 / R9: sample arrives partway up the ramp
        wait_tick(1'b0);
        while (m_cnt < 40) step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 1'b1, 8'd20);
        c0 = m_cnt;
        check("R9 ready low after handshake", smp_ready_o, 0);
        step(1'b1, 1'b0, 1'b1, 8'd77);
        c0 = c0 + 1;
        check("R9 second offer refused", smp_ready_o, 0);
        highs = 0;
        while (m_cnt != 255) begin
            step(1'b1, 1'b0, 1'b0, 8'h00);
            highs += int'(pwm_o);
        end
        check("R4 rising ramp keeps old compare", highs, 99 - c0);
        step(1'b1, 1'b0, 1'b0, 8'h00);
        check("R9 ready back after reload", smp_ready_o, 1);
        wait_tick(1'b0);
        run_count(PERIOD_CYC, 1'b0, highs, ticks);
        check("R4 new compare 20 in force", highs, 39);

        // R8: disable mid-period, then re-enable
        while (m_cnt < 10) step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        check("R8 pwm low when disabled", pwm_o, 0);
        check("R8 no tick when disabled", tick_o, 0);
        repeat (5) step(1'b0, 1'b1, 1'b0, 8'h00);
        check("R8 pwm low when disabled inverted", pwm_o, 0);
        wait_n = 0;
        for (int i = 0; i < 2 * PERIOD_CYC; i++) begin
            step(1'b1, 1'b0, 1'b0, 8'h00);
            wait_n++;
            if (tick_o) break;
        end
        check("R8 first tick after enable", wait_n, PERIOD_CYC);

        // Random stimulus against the reference model
        for (int i = 0; i < 20000; i++) begin
            logic en_r, inv_r, vld_r;
            en_r  = ($urandom % 300) != 0;
            inv_r = (i / 4000) % 2 == 1;
            vld_r = ($urandom % 2) == 1;
            step(en_r, inv_r, vld_r, 8'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule